// File: doc/BRIEF.md
# Bit Count and Field Manipulation Unit

This unit computes the bit-counting and bit-field results of a 32-bit integer pipeline. It covers six operations: leading-zero count, leading-one count, field extract, field insert, byte swap inside each halfword, and sign extension of a byte or a halfword. A one-bit class select chooses between the two opcode classes, and a 6-bit function code picks the operation inside the class. The shuffle-class operations also decode the 5-bit shift-amount field. The 5-bit destination-register field carries the field width or top bit.

The result is computed combinationally and then held in one register stage. An operation presented with `in_valid` high at a rising edge appears on `out_result` and `out_illegal` after that edge, together with `out_valid`. A field specification or code that cannot be decoded raises the illegal flag and forces the result to zero.

Top module: `bitfield_unit`

## Requirements
- R1: With `op_class`=0 and `func`=0x20, the result is the number of zero bits above the highest 1 bit of `rs_val`; it is 32 when `rs_val` is zero.
- R2: With `op_class`=0 and `func`=0x21, the result is the number of one bits above the highest 0 bit of `rs_val`; it is 32 when `rs_val` is all ones.
- R3: With `op_class`=1 and `func`=0x00, the result is `rs_val[top:sa]` with top = `sa`+`rd_f`, right-justified and zero-filled.
- R4: An extract whose `sa`+`rd_f` exceeds 31 raises `out_illegal` and returns 0.
- R5: With `op_class`=1 and `func`=0x04, the result equals `rt_val` with bits [`rd_f`:`sa`] replaced by the low (`rd_f`-`sa`+1) bits of `rs_val`.
- R6: An insert whose `rd_f` is below `sa` raises `out_illegal` and returns 0.
- R7: With `op_class`=1, `func`=0x20 and `sa`=0x02, the result swaps the two bytes inside each 16-bit half of `rt_val`.
- R8: With `op_class`=1 and `func`=0x20, `sa`=0x10 sign-extends `rt_val[7:0]` and `sa`=0x18 sign-extends `rt_val[15:0]` to 32 bits.
- R9: Under `op_class`=1 and `func`=0x20, any other `sa` value raises `out_illegal` with result 0, and so does any function code not listed above in either class.
- R10: The outputs follow `in_valid` by exactly one rising edge; in a cycle where `out_valid` is low, `out_result` is 0 and `out_illegal` is low.
- R11: While `rst` is high at a rising edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_class | input | 1 | 0 = counting class, 1 = field/shuffle class |
| func | input | 6 | Function code |
| sa | input | 5 | Shift-amount field (field low bit or shuffle selector) |
| rd_f | input | 5 | Destination field (field width-1 or field top bit) |
| rs_val | input | 32 | First operand |
| rt_val | input | 32 | Second operand |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Result value |
| out_illegal | output | 1 | Undecodable operation or field |

## Verification
The counts are tried with all-zero and all-one operands, a single set bit at each end, and mixed words. These inputs separate an off-by-one in the scan index from a missing saturation at 32. Extract and insert are tried at zero width, full width, top-aligned fields and fields one past the legal edge, which tells mask-width errors apart from the bounds check. The shuffle codes are tried with sign bits set and clear, and alongside neighbouring invalid selector values. A long stream of pseudo-random operations across all codes is compared against a behavioural model on every clock.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;

    localparam int DATA_W = 32;
    localparam int POS_W  = 5;

    localparam logic [5:0] FN_CLZ  = 6'h20;
    localparam logic [5:0] FN_CLO  = 6'h21;
    localparam logic [5:0] FN_EXT  = 6'h00;
    localparam logic [5:0] FN_INS  = 6'h04;
    localparam logic [5:0] FN_SHUF = 6'h20;

    localparam logic [4:0] SEL_SWAP = 5'h02;
    localparam logic [4:0] SEL_SEXB = 5'h10;
    localparam logic [4:0] SEL_SEXH = 5'h18;

    typedef enum logic [2:0] {
        K_CLZ, K_CLO, K_EXT, K_INS, K_SHUF, K_BAD
    } op_kind_e;

    typedef struct packed {
        logic              bad;
        logic [DATA_W-1:0] value;
    } unit_out_t;

    // mask with the n low bits set, n in 0..DATA_W
    function automatic logic [DATA_W-1:0] low_mask(input logic [POS_W:0] n);
        logic [DATA_W:0] wide;
        wide = ({{DATA_W{1'b0}}, 1'b1} << n) - 1'b1;
        return wide[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/bitfield_lead_count.sv
module bitfield_lead_count #(
    parameter int W     = 32,
    parameter bit ONES  = 1'b0,
    localparam int CW   = $clog2(W) + 1
) (
    input  logic [W-1:0]  operand,
    output logic [CW-1:0] count
);
    logic [W-1:0] scan;

    generate
        if (ONES) begin : g_ones
            assign scan = ~operand;
        end else begin : g_zeros
            assign scan = operand;
        end
    endgenerate

    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (scan[i]) count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/bitfield_field.sv
module bitfield_field
    import bitfield_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int PW = POS_W
) (
    input  logic          do_insert,
    input  logic [W-1:0]  rs_in,
    input  logic [W-1:0]  rt_in,
    input  logic [PW-1:0] hi_f,
    input  logic [PW-1:0] lo_f,
    output unit_out_t     res
);
    logic [PW:0]  top_sum;
    logic [PW:0]  ext_w;
    logic [PW:0]  ins_w;
    logic [W-1:0] ins_mask;

    always_comb begin
        top_sum  = {1'b0, hi_f} + {1'b0, lo_f};
        ext_w    = {1'b0, hi_f} + 1'b1;
        ins_w    = {1'b0, hi_f} - {1'b0, lo_f} + 1'b1;
        ins_mask = low_mask(ins_w) << lo_f;
        res      = '0;
        if (do_insert) begin
            if (hi_f < lo_f) res.bad = 1'b1;
            else res.value = (rt_in & ~ins_mask) | ((rs_in << lo_f) & ins_mask);
        end else begin
            if (top_sum > (PW+1)'(W - 1)) res.bad = 1'b1;
            else res.value = (rs_in >> lo_f) & low_mask(ext_w);
        end
    end
endmodule

// File: rtl/bitfield_shuffle.sv
module bitfield_shuffle
    import bitfield_pkg::*;
(
    input  logic [4:0]        sel,
    input  logic [DATA_W-1:0] rt_in,
    output unit_out_t         res
);
    always_comb begin
        res = '0;
        unique case (sel)
            SEL_SWAP: res.value = {rt_in[23:16], rt_in[31:24], rt_in[7:0], rt_in[15:8]};
            SEL_SEXB: res.value = {{(DATA_W-8){rt_in[7]}}, rt_in[7:0]};
            SEL_SEXH: res.value = {{(DATA_W-16){rt_in[15]}}, rt_in[15:0]};
            default:  res.bad   = 1'b1;
        endcase
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bitfield_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_class,
    input  logic [5:0]        func,
    input  logic [4:0]        sa,
    input  logic [4:0]        rd_f,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);
    localparam int CW = $clog2(DATA_W) + 1;

    op_kind_e     kind;
    logic [CW-1:0] zcount, ocount;
    unit_out_t    fld_res, shf_res, sel_res;

    always_comb begin
        kind = K_BAD;
        if (!op_class) begin
            if (func == FN_CLZ) kind = K_CLZ;
            else if (func == FN_CLO) kind = K_CLO;
        end else begin
            if (func == FN_EXT) kind = K_EXT;
            else if (func == FN_INS) kind = K_INS;
            else if (func == FN_SHUF) kind = K_SHUF;
        end
    end

    bitfield_lead_count #(.W(DATA_W), .ONES(1'b0)) u_clz (
        .operand(rs_val), .count(zcount)
    );
    bitfield_lead_count #(.W(DATA_W), .ONES(1'b1)) u_clo (
        .operand(rs_val), .count(ocount)
    );
    bitfield_field #(.W(DATA_W), .PW(POS_W)) u_field (
        .do_insert(kind == K_INS), .rs_in(rs_val), .rt_in(rt_val),
        .hi_f(rd_f), .lo_f(sa), .res(fld_res)
    );
    bitfield_shuffle u_shuf (
        .sel(sa), .rt_in(rt_val), .res(shf_res)
    );

    always_comb begin
        sel_res = '0;
        case (kind)
            K_CLZ:         sel_res.value = DATA_W'(zcount);
            K_CLO:         sel_res.value = DATA_W'(ocount);
            K_EXT, K_INS:  sel_res = fld_res;
            K_SHUF:        sel_res = shf_res;
            default:       sel_res.bad = 1'b1;
        endcase
        if (sel_res.bad) sel_res.value = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= sel_res.value;
                out_illegal <= sel_res.bad;
            end else begin
                out_result  <= '0;
                out_illegal <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        op_class,
    input logic [5:0]  func,
    input logic [4:0]  sa,
    input logic [4:0]  rd_f,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        out_valid,
    input logic [31:0] out_result,
    input logic        out_illegal
);
    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_result == 32'd0 && !out_illegal));
    assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_result == 32'd0);
    assert_clz_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_class && func == 6'h20 && rs_val == 32'd0) |=> out_result == 32'd32);
    assert_clo_ones_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_class && func == 6'h21 && rs_val == 32'hFFFF_FFFF) |=> out_result == 32'd32);
    assert_ins_bad_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_class && func == 6'h04 && rd_f < sa) |=> out_illegal);
    assert_reset_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == 32'd0));
endmodule

bind bitfield_unit bitfield_unit_chk u_chk (.*);

// File: tb/bitfield_unit_tb.sv
module bitfield_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        op_class = 1'b0;
    logic [5:0]  func = '0;
    logic [4:0]  sa = '0;
    logic [4:0]  rd_f = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_illegal;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bitfield_unit u_dut (.*);

    // behavioural reference
    function automatic void model(input bit cls, input int fn, input int s, input int d,
                                  input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output bit ill);
        r = 0; ill = 0;
        if (!cls && (fn == 32 || fn == 33)) begin
            int n = 0;
            int k = 31;
            while (k >= 0 && a[k] == (fn == 33)) begin n++; k--; end
            r = n;
        end else if (cls && fn == 0) begin
            if (s + d > 31) ill = 1;
            else for (int i = 0; i <= d; i++) r[i] = a[s+i];
        end else if (cls && fn == 4) begin
            if (d < s) ill = 1;
            else begin
                r = b;
                for (int i = s; i <= d; i++) r[i] = a[i-s];
            end
        end else if (cls && fn == 32) begin
            if (s == 2) r = {b[23:16], b[31:24], b[7:0], b[15:8]};
            else if (s == 16) r = $signed(b[7:0]);
            else if (s == 24) r = $signed(b[15:0]);
            else ill = 1;
        end else ill = 1;
    endfunction

    function automatic string tag_of(input bit cls, input int fn, input int s, input int d);
        if (!cls && fn == 32) return "R1";
        if (!cls && fn == 33) return "R2";
        if (cls && fn == 0) return (s + d > 31) ? "R4" : "R3";
        if (cls && fn == 4) return (d < s) ? "R6" : "R5";
        if (cls && fn == 32 && s == 2) return "R7";
        if (cls && fn == 32 && (s == 16 || s == 24)) return "R8";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [31:0] er, input bit ei, input bit ev);
        total++;
        if (out_result !== er || out_illegal !== ei || out_valid !== ev) begin
            bad++;
            $display("FAIL %s: result=%h illegal=%b valid=%b expected result=%h illegal=%b valid=%b",
                     tag, out_result, out_illegal, out_valid, er, ei, ev);
        end
    endtask

    task automatic run_op(input bit cls, input int fn, input int s, input int d,
                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        bit ei;
        @(negedge clk);
        in_valid = 1; op_class = cls; func = 6'(fn); sa = 5'(s); rd_f = 5'(d);
        rs_val = a; rt_val = b;
        model(cls, fn, s, d, a, b, er, ei);
        @(negedge clk);
        in_valid = 0;
        check(tag_of(cls, fn, s, d), er, ei, 1'b1);
    endtask

    task automatic idle_check;
        @(negedge clk);
        in_valid = 0; rs_val = 32'hDEAD_BEEF; func = 6'h20;
        @(negedge clk);
        check("R10", 32'd0, 1'b0, 1'b0);
    endtask

    initial begin
        logic [31:0] lf = 32'h1234_5678;
        repeat (3) @(negedge clk);
        check("R11", 32'd0, 1'b0, 1'b0);
        rst = 0;
        // R1 leading zeros
        run_op(0, 32, 0, 0, 32'h0, 0);
        run_op(0, 32, 0, 0, 32'h8000_0000, 0);
        run_op(0, 32, 0, 0, 32'h0001_0000, 0);
        run_op(0, 32, 0, 0, 32'h1, 0);
        // R2 leading ones
        run_op(0, 33, 0, 0, 32'hFFFF_FFFF, 0);
        run_op(0, 33, 0, 0, 32'h7FFF_FFFF, 0);
        run_op(0, 33, 0, 0, 32'hF0F0_0000, 0);
        run_op(0, 33, 0, 0, 32'hFFFF_FFFE, 0);
        // R3 / R4 extract
        run_op(1, 0, 4, 7, 32'hABCD_1234, 0);
        run_op(1, 0, 0, 31, 32'hCAFE_F00D, 0);
        run_op(1, 0, 31, 0, 32'h8000_0000, 0);
        run_op(1, 0, 12, 20, 32'hFFFF_FFFF, 0);
        run_op(1, 0, 1, 31, 32'hFFFF_FFFF, 0);
        // R5 / R6 insert
        run_op(1, 4, 8, 15, 32'h0000_00AB, 32'h1122_3344);
        run_op(1, 4, 5, 5, 32'hFFFF_FFFF, 32'h0);
        run_op(1, 4, 0, 31, 32'h89AB_CDEF, 32'h0123_4567);
        run_op(1, 4, 9, 8, 32'hFFFF_FFFF, 32'h5555_5555);
        // R7 / R8 shuffle
        run_op(1, 32, 2, 0, 0, 32'h1122_3344);
        run_op(1, 32, 16, 0, 0, 32'h1234_5680);
        run_op(1, 32, 16, 0, 0, 32'hFFFF_FF7F);
        run_op(1, 32, 24, 0, 0, 32'h0000_8001);
        run_op(1, 32, 24, 0, 0, 32'hFFFF_7FFF);
        // R9 illegal selectors and codes
        run_op(1, 32, 3, 0, 0, 32'h1234_5678);
        run_op(1, 32, 17, 0, 0, 32'h1234_5678);
        run_op(0, 0, 0, 0, 32'h1, 32'h1);
        run_op(1, 33, 0, 0, 32'h1, 32'h1);
        // R10 idle
        idle_check();
        // random stream
        for (int n = 0; n < 400; n++) begin
            int pick;
            int fns[6] = '{32, 33, 0, 4, 32, 5};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            pick = int'(lf[2:0]) % 6;
            run_op(pick >= 2, fns[pick], (pick == 4) ? ((lf[9]) ? 2 : {27'd0, lf[13:9]}) : int'(lf[8:4]),
                   int'(lf[14:10]), lf ^ 32'h5A5A_0F0F, {lf[15:0], lf[31:16]});
            if (lf[20]) idle_check();
        end
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule